// File: doc/BRIEF.md
# Erased Page Zero-Bit Detector

When the error decoder reports that a sector cannot be corrected, the sector may simply be a page that was erased and never programmed. An erased page reads back as all ones, and its stored check field is all ones as well. That check field does not match the code computed over all-ones data, so the decoder rejects a page that is actually valid. This block sees the sector bytes on their way past and makes the final call. It counts the bits that read as zero, first in the 512-byte data region and then in the 13-byte check region.

Each region has its own valid and last-byte strobe on a shared byte bus. A start pulse opens a new sector. One cycle after the last check byte is accepted, the block pulses done. At that point it presents the data-region zero count and one of two results. The first is an erased verdict, which means the flipped bits count as corrected. The second is an uncorrectable verdict. With an erased verdict, the block also raises a request that the data region be overwritten with ones whenever that region had at least one zero bit. Once a region counter has passed the correction limit it stops growing, so the counters stay narrow.

Top module: `erased_page_detector`

## Requirements
- R1: The zero count of an accepted byte equals the population count of its bitwise inverse. The reported data count is the sum of these counts over all accepted data-region bytes.
- R2: The sector is declared erased (erased_o = 1, fail_o = 0) when the data-region zero count plus the check-region zero count is at most 8.
- R3: The sector is declared uncorrectable (fail_o = 1, erased_o = 0) when the combined zero count is 9 or more.
- R4: fill_req_o is 1 only when the sector is erased and the data-region count is nonzero. An erased sector whose data region has no zero bits leaves it at 0.
- R5: Each region counter saturates at 9 and stops counting there. data_zeros_o reports 9 when the data region holds more than 8 zero bits.
- R6: done_o is high for exactly one cycle, in the cycle after the check byte flagged as last is accepted. The results appear in that same cycle and hold until the next start.
- R7: A start pulse clears both counters and all outputs in the next cycle. A byte presented in the same cycle as start is not counted.
- R8: Once a region's last byte has been accepted, further bytes for that region are ignored until the next start. A second check-region last byte produces no done pulse and leaves the results unchanged.
- R9: After reset, done_o, erased_o, fail_o, fill_req_o and data_zeros_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Opens a new sector and clears counts and results |
| dat_valid_i | input | 1 | byte_i carries a data-region byte |
| dat_last_i | input | 1 | Marks the final data-region byte |
| chk_valid_i | input | 1 | byte_i carries a check-region byte |
| chk_last_i | input | 1 | Marks the final check-region byte |
| byte_i | input | 8 | Sector byte |
| done_o | output | 1 | One-cycle pulse when the verdict is ready |
| data_zeros_o | output | 4 | Saturated zero-bit count of the data region |
| erased_o | output | 1 | Sector treated as an erased page |
| fill_req_o | output | 1 | Request to overwrite the data region with ones |
| fail_o | output | 1 | Sector is uncorrectable |

## Verification
Several sector patterns are streamed through the block:

- An all-ones sector must give an erased verdict with no fill request.
- A split of 5 data zeros and 3 check zeros sits exactly on the limit and must be accepted with a fill request.
- Moving one more zero into the check region must flip the verdict to uncorrectable. Together these two cases separate a correct at-most-8 comparison from an off-by-one.
- Zeros placed only in the check region separate the fill request from the erased flag.
- Three all-zero data bytes exercise saturation.

Stray bytes are sent after each last strobe, and a byte arrives together with start. These cases show whether region closing and start priority hold.

// File: rtl/epd_pkg.sv
package epd_pkg;

  // Saturating accumulate: once acc + inc passes sat, the result stays at sat.
  function automatic int unsigned sat_step(int unsigned acc, int unsigned inc,
                                           int unsigned sat);
    int unsigned s;
    s = acc + inc;
    return (s > sat) ? sat : s;
  endfunction

  // Erased-page decision: the combined zero count must not exceed the limit.
  function automatic bit within_limit(int unsigned a, int unsigned b,
                                      int unsigned lim);
    return (a + b) <= lim;
  endfunction

  // Population count of a vector of up to 64 bits.
  function automatic int unsigned ones_in(logic [63:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 64; i++) n += int'(v[i]);
    return n;
  endfunction

endpackage

// File: rtl/epd_byte_zeros.sv
module epd_byte_zeros #(
  parameter int BYTE_W = 8,
  parameter int ZW     = $clog2(BYTE_W + 1)
) (
  input  logic [BYTE_W-1:0] byte_i,
  output logic [ZW-1:0]     zeros_o
);
  import epd_pkg::*;

  logic [63:0] inv_w;

  generate
    for (genvar g = 0; g < 64; g++) begin : g_inv
      if (g < BYTE_W) begin : g_live
        assign inv_w[g] = ~byte_i[g];
      end else begin : g_pad
        assign inv_w[g] = 1'b0;
      end
    end
  endgenerate

  assign zeros_o = ZW'(ones_in(inv_w));

endmodule

// File: rtl/epd_sat_counter.sv
module epd_sat_counter #(
  parameter int INC_W = 4,
  parameter int SAT   = 9,
  parameter int CNT_W = $clog2(SAT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             valid_i,
  input  logic             last_i,
  input  logic [INC_W-1:0] inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] next_o,
  output logic             fire_o
);
  import epd_pkg::*;

  logic             open_q;
  logic [CNT_W-1:0] cnt_q;
  logic             full_w;
  logic             accept_w;
  logic [CNT_W-1:0] cnt_d;

  assign full_w   = (cnt_q == CNT_W'(SAT));
  assign accept_w = valid_i & open_q & ~clr_i;
  assign cnt_d    = (accept_w && !full_w)
                    ? CNT_W'(sat_step(32'(cnt_q), 32'(inc_i), SAT))
                    : cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      open_q <= 1'b1;
    end else if (clr_i) begin
      cnt_q  <= '0;
      open_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      if (accept_w && last_i) open_q <= 1'b0;
    end
  end

  assign cnt_o  = cnt_q;
  assign next_o = cnt_d;
  assign fire_o = accept_w & last_i;

  // R7: start empties the counter
  a_r7_counter_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));

  // R8: a closed region ignores further bytes
  a_r8_closed_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!open_q && !clr_i) |=> $stable(cnt_q));

  // R5: saturation is sticky until cleared
  a_r5_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (full_w && !clr_i) |=> (cnt_q == CNT_W'(SAT)));

endmodule

// File: rtl/epd_verdict.sv
module epd_verdict #(
  parameter int LIMIT = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             fire_i,
  input  logic [CNT_W-1:0] dnext_i,
  input  logic [CNT_W-1:0] cnext_i,
  output logic             done_o,
  output logic             erased_o,
  output logic             fail_o,
  output logic             fill_o,
  output logic [CNT_W-1:0] dcount_o
);
  import epd_pkg::*;

  logic ok_w;
  assign ok_w = within_limit(32'(dnext_i), 32'(cnext_i), LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o   <= 1'b0;
      erased_o <= 1'b0;
      fail_o   <= 1'b0;
      fill_o   <= 1'b0;
      dcount_o <= '0;
    end else if (clr_i) begin
      done_o   <= 1'b0;
      erased_o <= 1'b0;
      fail_o   <= 1'b0;
      fill_o   <= 1'b0;
      dcount_o <= '0;
    end else if (fire_i) begin
      done_o   <= 1'b1;
      erased_o <= ok_w;
      fail_o   <= ~ok_w;
      fill_o   <= ok_w && (dnext_i != '0);
      dcount_o <= dnext_i;
    end else begin
      done_o   <= 1'b0;
    end
  end

  // R6: the verdict follows the accepted last check byte by one cycle
  a_r6_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_i && !clr_i) |=> done_o);

  // R6: done is a single-cycle pulse
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7: start clears all result flags
  a_r7_flags_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !(done_o || erased_o || fail_o || fill_o));

  // R6: results stay put between verdicts
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !fire_i) |=> ($stable(erased_o) && $stable(fail_o) && $stable(dcount_o)));

endmodule

// File: rtl/erased_page_detector.sv
module erased_page_detector #(
  parameter int BYTE_W = 8,
  parameter int LIMIT  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              dat_valid_i,
  input  logic              dat_last_i,
  input  logic              chk_valid_i,
  input  logic              chk_last_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              done_o,
  output logic [$clog2(LIMIT+2)-1:0] data_zeros_o,
  output logic              erased_o,
  output logic              fill_req_o,
  output logic              fail_o
);
  localparam int SAT   = LIMIT + 1;
  localparam int CNT_W = $clog2(SAT + 1);
  localparam int ZW    = $clog2(BYTE_W + 1);

  logic [ZW-1:0]    byte_zeros_w;
  logic [CNT_W-1:0] dat_cnt_w, dat_next_w, chk_cnt_w, chk_next_w;
  logic             dat_fire_w, chk_fire_w;

  epd_byte_zeros #(.BYTE_W(BYTE_W), .ZW(ZW)) u_zeros (
    .byte_i (byte_i),
    .zeros_o(byte_zeros_w)
  );

  epd_sat_counter #(.INC_W(ZW), .SAT(SAT), .CNT_W(CNT_W)) u_dat_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (start_i),
    .valid_i(dat_valid_i),
    .last_i (dat_last_i),
    .inc_i  (byte_zeros_w),
    .cnt_o  (dat_cnt_w),
    .next_o (dat_next_w),
    .fire_o (dat_fire_w)
  );

  epd_sat_counter #(.INC_W(ZW), .SAT(SAT), .CNT_W(CNT_W)) u_chk_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (start_i),
    .valid_i(chk_valid_i),
    .last_i (chk_last_i),
    .inc_i  (byte_zeros_w),
    .cnt_o  (chk_cnt_w),
    .next_o (chk_next_w),
    .fire_o (chk_fire_w)
  );

  epd_verdict #(.LIMIT(LIMIT), .CNT_W(CNT_W)) u_verdict (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (start_i),
    .fire_i  (chk_fire_w),
    .dnext_i (dat_next_w),
    .cnext_i (chk_next_w),
    .done_o  (done_o),
    .erased_o(erased_o),
    .fail_o  (fail_o),
    .fill_o  (fill_req_o),
    .dcount_o(data_zeros_o)
  );

  // R8: the data region closes after its last byte, so it cannot fire twice in a row
  a_r8_data_once: assert property (@(posedge clk) disable iff (!rst_n)
    dat_fire_w |=> !dat_fire_w);

  // R5: neither live counter ever passes the saturation value
  a_r5_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_cnt_w <= CNT_W'(SAT)) && (chk_cnt_w <= CNT_W'(SAT)));

  // R4: a fill request is only raised together with the erased verdict
  a_r4_fill_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fill_req_o) |-> (done_o && erased_o));

endmodule

// File: tb/erased_page_detector_tb_top.sv
module erased_page_detector_tb_top;
  localparam int DN = 512;
  localparam int CN = 13;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0, dat_valid_i = 1'b0, dat_last_i = 1'b0;
  logic       chk_valid_i = 1'b0, chk_last_i = 1'b0;
  logic [7:0] byte_i = 8'hFF;
  logic       done_o, erased_o, fill_req_o, fail_o;
  logic [3:0] data_zeros_o;

  int errs = 0;
  int checks = 0;
  logic [7:0] dbuf [DN];
  logic [7:0] cbuf [CN];

  always #5 clk = ~clk;

  erased_page_detector dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .dat_valid_i(dat_valid_i), .dat_last_i(dat_last_i),
    .chk_valid_i(chk_valid_i), .chk_last_i(chk_last_i),
    .byte_i(byte_i), .done_o(done_o), .data_zeros_o(data_zeros_o),
    .erased_o(erased_o), .fill_req_o(fill_req_o), .fail_o(fail_o)
  );

  task automatic ck(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int zc(logic [7:0] b);
    int n = 0;
    for (int i = 0; i < 8; i++) if (!b[i]) n++;
    return n;
  endfunction

  task automatic all_ones();
    for (int i = 0; i < DN; i++) dbuf[i] = 8'hFF;
    for (int i = 0; i < CN; i++) cbuf[i] = 8'hFF;
  endtask

  // Streams one sector. glitch: a zero byte rides with start (R7).
  // junk: stray bytes after each last strobe (R8).
  task automatic run(string name, bit glitch, bit junk);
    int d = 0, c = 0, ds, ok, fill;
    for (int i = 0; i < DN; i++) d += zc(dbuf[i]);
    for (int i = 0; i < CN; i++) c += zc(cbuf[i]);
    ds   = (d > 9) ? 9 : d;
    ok   = ((d + c) <= 8) ? 1 : 0;
    fill = (ok == 1 && d != 0) ? 1 : 0;
    @(negedge clk);
    start_i = 1'b1;
    if (glitch) begin dat_valid_i = 1'b1; byte_i = 8'h00; end
    @(negedge clk);
    start_i = 1'b0; dat_valid_i = 1'b0;
    for (int i = 0; i < DN; i++) begin
      dat_valid_i = 1'b1; byte_i = dbuf[i]; dat_last_i = (i == DN-1);
      @(negedge clk);
    end
    dat_valid_i = 1'b0; dat_last_i = 1'b0;
    if (junk) begin
      dat_valid_i = 1'b1; dat_last_i = 1'b1; byte_i = 8'h00;
      @(negedge clk);
      dat_valid_i = 1'b0; dat_last_i = 1'b0;
    end
    for (int i = 0; i < CN; i++) begin
      chk_valid_i = 1'b1; byte_i = cbuf[i]; chk_last_i = (i == CN-1);
      @(negedge clk);
    end
    chk_valid_i = 1'b0; chk_last_i = 1'b0;
    ck({name, " R6 done after last check byte"}, int'(done_o), 1);
    ck({name, " R1/R5 data count"}, int'(data_zeros_o), ds);
    ck({name, " R2 erased"}, int'(erased_o), ok);
    ck({name, " R3 fail"}, int'(fail_o), 1 - ok);
    ck({name, " R4 fill request"}, int'(fill_req_o), fill);
    if (junk) begin
      chk_valid_i = 1'b1; chk_last_i = 1'b1; byte_i = 8'h00;
      @(negedge clk);
      chk_valid_i = 1'b0; chk_last_i = 1'b0;
      ck({name, " R8 no second done"}, int'(done_o), 0);
      ck({name, " R8 erased unchanged"}, int'(erased_o), ok);
      ck({name, " R8 count unchanged"}, int'(data_zeros_o), ds);
    end else begin
      @(negedge clk);
      ck({name, " R6 done one cycle wide"}, int'(done_o), 0);
      ck({name, " R6 result held"}, int'(fail_o), 1 - ok);
    end
  endtask

  task automatic clear_test();
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    ck("R7 clear flags", int'({done_o, erased_o, fail_o, fill_req_o}), 0);
    ck("R7 clear count", int'(data_zeros_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    ck("R9 reset outputs", int'({done_o, erased_o, fail_o, fill_req_o}), 0);
    ck("R9 reset count", int'(data_zeros_o), 0);
    rst_n = 1'b1;

    all_ones();
    run("all ones", 1'b0, 1'b0);

    all_ones();
    dbuf[0] = 8'hF0; dbuf[DN-1] = 8'hFE; cbuf[0] = 8'h7F; cbuf[CN-1] = 8'hFC;
    run("limit 5+3", 1'b0, 1'b0);

    cbuf[6] = 8'hEF;
    run("over 5+4", 1'b0, 1'b0);
    clear_test();

    all_ones();
    dbuf[100] = 8'h00; dbuf[101] = 8'h00; dbuf[102] = 8'h00;
    run("saturate", 1'b0, 1'b0);

    all_ones();
    cbuf[3] = 8'h00;
    run("check only", 1'b0, 1'b0);

    all_ones();
    dbuf[7] = 8'hAA;
    run("stray bytes", 1'b0, 1'b1);

    all_ones();
    run("start with byte", 1'b1, 1'b0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule